// File: doc/BRIEF.md
# Programmable Card Clock Divider

This block makes the clock that drives a smart card contact from a faster input clock. A two-bit selector picks division by 1, 2, 4 or 8. For 2, 4 and 8 the output comes straight from a register stage that toggles on input rising edges. High and low phases therefore have the same length. For division by 1 the input clock is passed through a gate, and its duty cycle is passed through unchanged.

The output stays low until the card activation sequencer raises the enable. The block starts on a clean full-width pulse and stops only after a full low phase. A new ratio is taken up only at the end of a low phase. When the new ratio is longer, the low phase is stretched to the new half-period, so no shortened pulse reaches the card.

Top module: `card_clk_divider`

## Requirements
- R1: While rst_n is low, and afterwards until clk_enable is first seen high, card_clk is low.
- R2: The selector sets the ratio: div_sel 2'b00 divides by 4, 2'b01 by 8, 2'b10 by 2, and 2'b11 passes clk_in through.
- R3: At ratios 2, 4 and 8, each high phase and each low phase of card_clk lasts exactly half the selected period (1, 2 or 4 clk_in cycles).
- R4: Once the output has stopped after clk_enable falls, card_clk stays low for as long as clk_enable stays low.
- R5: In the idle state with a divided ratio selected, card_clk goes high at the first clk_in rising edge that samples clk_enable high, and that first high phase is full length.
- R6: After clk_enable falls, the pulse in progress completes at full width and the following low phase lasts at least one full half-period.
- R7: After div_sel changes, no high or low phase of card_clk is shorter than the shorter of the old and new half-periods. After the change, the output settles to the new ratio.
- R8: At ratio 1, card_clk follows clk_in during each clk_in high phase and is low during each clk_in low phase. It starts and stops only at a clk_in rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Ratio selector (see R2) |
| clk_enable | input | 1 | Run request from the activation sequencer |
| card_clk | output | 1 | Gated, divided clock to the card contact |

## Verification
A corrupt phase counter or half-period register shows at the port within one period: the next high or low run has the wrong length. The bench measures every run in half-cycles of clk_in. A state register stuck in the wrong place shows as a run of 1 half-cycle where a divided ratio is selected, or as a pulse after the enable has dropped. Most corruptions therefore appear within eight clk_in cycles. The checks on run lengths across ratio changes, taken at many phase offsets, catch a changeover made at the wrong moment.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;

    localparam int SEL_W = 2;
    localparam int PH_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_PASS
    } ccd_state_e;

    typedef struct packed {
        ccd_state_e        st;
        logic [PH_W-1:0]   phase;
        logic [PH_W-1:0]   half;
        logic              out;
    } ccd_seq_t;

endpackage

// File: rtl/card_clk_ratio_decode.sv
module card_clk_ratio_decode
    import card_clk_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output logic [PH_W-1:0]  half_len,
    output logic             pass_thru
);
    // half_len: length of one half-period in clk_in cycles
    always_comb begin
        pass_thru = 1'b0;
        half_len  = PH_W'(1);
        case (sel)
            2'b00:   half_len = PH_W'(2);
            2'b01:   half_len = PH_W'(4);
            2'b10:   half_len = PH_W'(1);
            default: pass_thru = 1'b1;
        endcase
    end

    always_comb begin
        a_r2_half_legal: assert (half_len == PH_W'(1) || half_len == PH_W'(2) || half_len == PH_W'(4));
    end
endmodule

// File: rtl/card_clk_seq.sv
module card_clk_seq
    import card_clk_pkg::*;
(
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             clk_enable,
    input  logic [PH_W-1:0]  dec_half,
    input  logic             dec_pass,
    output logic             div_out,
    output logic             pass_on
);
    ccd_seq_t seq_d, seq_q;
    logic     launch;
    logic     at_end;

    always_comb begin
        seq_d  = seq_q;
        launch = 1'b0;
        at_end = (seq_q.phase == seq_q.half - PH_W'(1));
        case (seq_q.st)
            ST_IDLE: begin
                seq_d.out = 1'b0;
                if (clk_enable) launch = 1'b1;
            end
            ST_HIGH: begin
                if (at_end) begin
                    seq_d.st    = ST_LOW;
                    seq_d.out   = 1'b0;
                    seq_d.phase = '0;
                end else begin
                    seq_d.phase = seq_q.phase + PH_W'(1);
                end
            end
            ST_LOW: begin
                if (!at_end) begin
                    seq_d.phase = seq_q.phase + PH_W'(1);
                end else if (!clk_enable) begin
                    seq_d.st = ST_IDLE;
                end else if (!dec_pass && (dec_half > seq_q.half)) begin
                    // stretch the low phase to the longer new half-period
                    seq_d.half  = dec_half;
                    seq_d.phase = seq_q.phase + PH_W'(1);
                end else begin
                    launch = 1'b1;
                end
            end
            default: begin // ST_PASS
                if (!clk_enable || !dec_pass) begin
                    seq_d.st    = ST_LOW;
                    seq_d.out   = 1'b0;
                    seq_d.phase = '0;
                    seq_d.half  = dec_half + PH_W'(1);
                end
            end
        endcase
        if (launch) begin
            seq_d.phase = '0;
            if (dec_pass) begin
                seq_d.st  = ST_PASS;
                seq_d.out = 1'b0;
            end else begin
                seq_d.st   = ST_HIGH;
                seq_d.out  = 1'b1;
                seq_d.half = dec_half;
            end
        end
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, phase: '0, half: PH_W'(1), out: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign div_out = seq_q.out;
    assign pass_on = (seq_q.st == ST_PASS);

    a_r1_idle_low: assert property (@(posedge clk_in) disable iff (!rst_n)
        (seq_q.st == ST_IDLE) |-> !div_out);
    a_r3_high_held: assert property (@(posedge clk_in) disable iff (!rst_n)
        (seq_q.st == ST_HIGH && seq_q.phase != seq_q.half - PH_W'(1)) |=> div_out);
    a_r5_start_rise: assert property (@(posedge clk_in) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && clk_enable && !dec_pass) |=> div_out);
    a_r6_stop_low: assert property (@(posedge clk_in) disable iff (!rst_n)
        (seq_q.st == ST_LOW && !clk_enable) |=> !div_out);
    a_r8_pass_quiet: assert property (@(posedge clk_in) disable iff (!rst_n)
        pass_on |-> !div_out);
endmodule

// File: rtl/card_clk_gate.sv
module card_clk_gate (
    input  logic clk_in,
    input  logic rst_n,
    input  logic pass_on,
    input  logic div_out,
    output logic card_clk
);
    logic gate_d, gate_q;

    always_comb gate_d = pass_on;

    // updated while clk_in is low so the pass-through never cuts a pulse
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end

    assign card_clk = div_out | (clk_in & gate_q);

    a_r8_one_source: assert property (@(posedge clk_in) disable iff (!rst_n)
        !(gate_q && div_out));
endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
    import card_clk_pkg::*;
(
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             clk_enable,
    output logic             card_clk
);
    logic [PH_W-1:0] dec_half;
    logic            dec_pass;
    logic            div_out;
    logic            pass_on;

    card_clk_ratio_decode u_decode (
        .sel       (div_sel),
        .half_len  (dec_half),
        .pass_thru (dec_pass)
    );

    card_clk_seq u_seq (
        .clk_in     (clk_in),
        .rst_n      (rst_n),
        .clk_enable (clk_enable),
        .dec_half   (dec_half),
        .dec_pass   (dec_pass),
        .div_out    (div_out),
        .pass_on    (pass_on)
    );

    card_clk_gate u_gate (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .pass_on  (pass_on),
        .div_out  (div_out),
        .card_clk (card_clk)
    );
endmodule

// File: tb/card_clk_divider_bench.sv
`timescale 1ns/1ps
module card_clk_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       clk_enable = 1'b0;
    logic       card_clk;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    card_clk_divider u_card_clk_divider (
        .clk_in     (clk),
        .rst_n      (rst_n),
        .div_sel    (div_sel),
        .clk_enable (clk_enable),
        .card_clk   (card_clk)
    );

    // run-length monitor, one sample per half-cycle, 2 ns after each edge
    logic prev_s;
    bit   have_prev, started;
    int   run_len, min_h, max_h, min_l, max_l, n_high;

    task automatic stats_clear();
        have_prev = 0; started = 0;
        min_h = 999; max_h = 0; min_l = 999; max_l = 0; n_high = 0;
    endtask

    always begin
        @(clk);
        #2;
        if (card_clk) n_high++;
        if (!have_prev) begin
            prev_s = card_clk; have_prev = 1; run_len = 1;
        end else if (card_clk == prev_s) begin
            run_len++;
        end else begin
            if (started) begin
                if (prev_s) begin
                    if (run_len < min_h) min_h = run_len;
                    if (run_len > max_h) max_h = run_len;
                end else begin
                    if (run_len < min_l) min_l = run_len;
                    if (run_len > max_l) max_l = run_len;
                end
            end
            started = 1; prev_s = card_clk; run_len = 1;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int hc_of(logic [1:0] s);
        case (s)
            2'b00: return 4;
            2'b01: return 8;
            2'b10: return 2;
            default: return 1;
        endcase
    endfunction

    task automatic go_idle();
        @(negedge clk); clk_enable = 0;
        cycles(20);
    endtask

    task automatic t_reset();
        stats_clear();
        rst_n = 0; clk_enable = 0;
        cycles(5);
        check(n_high == 0 && card_clk == 0, "R1 low in reset", n_high, 0);
        @(negedge clk); rst_n = 1;
        stats_clear();
        cycles(10);
        check(n_high == 0, "R1 low until enabled", n_high, 0);
    endtask

    task automatic t_ratio(logic [1:0] s);
        int e;
        e = hc_of(s);
        go_idle();
        div_sel = s; clk_enable = 1;
        cycles(10);
        stats_clear();
        cycles(48);
        check(min_h == e && max_h == e, "R2 high run", min_h, e);
        check(min_l == e && max_l == e, "R3 low run", min_l, e);
        if (s == 2'b11) check(min_h == 1 && n_high > 40, "R8 pass follows clk_in", n_high, 48);
    endtask

    task automatic t_start(logic [1:0] s);
        int e;
        e = hc_of(s);
        go_idle();
        div_sel = s;
        stats_clear();
        @(negedge clk); clk_enable = 1;
        @(posedge clk); #2;
        check(card_clk == 1, "R5 rise at first edge", card_clk, 1);
        cycles(20);
        check(min_h == e, "R5 first pulse full", min_h, e);
    endtask

    task automatic t_stop(logic [1:0] s, int offs);
        int e;
        e = hc_of(s);
        go_idle();
        div_sel = s; clk_enable = 1;
        cycles(10 + offs);
        stats_clear();
        clk_enable = 0;
        cycles(24);
        check(max_h == 0 || min_h == e, "R6 last pulse full", min_h, e);
        stats_clear();
        cycles(30);
        check(n_high == 0, "R4 stays low while disabled", n_high, 0);
    endtask

    task automatic t_switch(logic [1:0] a, logic [1:0] b);
        int lo, e;
        lo = (hc_of(a) < hc_of(b)) ? hc_of(a) : hc_of(b);
        e  = hc_of(b);
        for (int off = 0; off < 8; off++) begin
            go_idle();
            div_sel = a; clk_enable = 1;
            cycles(10 + off);
            stats_clear();
            div_sel = b;
            cycles(40);
            check(min_h >= lo && min_l >= lo, "R7 no runt on change", (min_h < min_l) ? min_h : min_l, lo);
            stats_clear();
            cycles(40);
            check(min_h == e && max_l == e, "R7 settled to new ratio", max_l, e);
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        stats_clear();
        t_reset();
        t_ratio(2'b00);
        t_ratio(2'b01);
        t_ratio(2'b10);
        t_ratio(2'b11);
        t_start(2'b01);
        t_start(2'b10);
        t_stop(2'b01, 0);
        t_stop(2'b01, 3);
        t_stop(2'b11, 1);
        t_switch(2'b01, 2'b10);
        t_switch(2'b10, 2'b01);
        t_switch(2'b00, 2'b11);
        t_switch(2'b11, 2'b01);
        t_switch(2'b11, 2'b10);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule